// File: doc/BRIEF.md
# Centre-Aligned Dual-Slope PWM Timer

This block is a 16-bit up/down timer that drives two symmetric, centre-aligned pulse-width-modulated outputs, channel A and channel B. The counter climbs from zero to a programmable ceiling (TOP) and then falls back to zero, over and over. Each channel compares the count with its own compare value. Because the counter ramps up and then down, every pulse is centred in the period. This suits motor and power-stage drive, where the pulse centres of several phases must stay aligned.

Software sets the block up through a small write port. It picks a count rate from a free-running prescaler and chooses where TOP comes from: a dedicated ceiling register or the channel A compare value. Each output is set to non-inverting, inverting or disconnected, and each has an enable gate. Compare and ceiling writes land in buffer registers. The active copies take the buffered values only while the counter sits at zero. Each period therefore runs to completion with one consistent set of values, which keeps both phase and frequency intact when the ceiling changes on the fly.

The counting engine is a two-state machine, `ST_RISE` and `ST_FALL`. The transition `RISE_TO_FALL` fires on the prescaled tick that brings the count up to TOP. The transition `FALL_TO_RISE` fires on the tick that brings it down to zero. On any other tick the state is kept (`RISE_STEP`, `FALL_STEP`), and with no tick everything holds.

Top module: `pwm_dual_slope`

## Requirements
- R1: On each count tick the counter moves by one. In state `ST_RISE` it goes up, and when it reaches TOP the next tick moves it to TOP-1. In state `ST_FALL` it goes down, and when it reaches zero the next tick moves it to 1. Zero and TOP each last exactly one tick, so one period is 2·TOP ticks.
- R2: `down_o` is 1 while the count is at TOP or descending (`ST_FALL`). It is 0 while the count is at zero or ascending (`ST_RISE`).
- R3: Non-inverting mode (2-bit mode code 2'b10) drives the channel high when the counter is rising and the count is below the compare value. It also drives the channel high when the counter is falling and the count is at or below the compare value. The channel is therefore high for 2·cmp ticks of each period.
- R4: Inverting mode (code 2'b11) gives the exact complement of non-inverting mode, cycle for cycle.
- R5: A compare value of zero keeps a non-inverting output low for the whole period. A compare value at or above TOP keeps it high for the whole period. Inverting mode gives the opposite levels.
- R6: Control bit 3 selects the TOP source: 0 takes the ceiling register, 1 takes the active channel A compare value.
- R7: A TOP value below 3 is treated as 3.
- R8: Control bits [2:0] set the count-tick divide: code 1 gives ÷1, 2 gives ÷8, 3 gives ÷64, 4 gives ÷256 and 5 gives ÷1024 of the clock.
- R9: Clock-select codes 0, 6 and 7 stop the counter. The count then holds its value.
- R10: The write port updates buffers. Address 1 writes compare A, 2 writes compare B and 3 writes the ceiling. The active compare and ceiling values take the buffers only on clocks where the count is zero, so a change made mid-period first acts in the next period.
- R11: Control bit 8 (channel A) and bit 9 (channel B) are output enables. With the enable at 0, the pin is low.
- R12: Mode codes 2'b00 and 2'b01 disconnect a channel, and its pin is held low. Control bits [5:4] hold channel A's mode and bits [7:6] hold channel B's mode.
- R13: Address 0 writes the control register, which takes effect on the next clock. After reset all registers are zero, the count is zero, `down_o` is 0 and both pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 compare A, 2 compare B, 3 ceiling |
| wr_data | input | 16 | Write data |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| cnt_o | output | 16 | Current count |
| down_o | output | 1 | Slope flag, 1 when descending |

## Verification
The bench sweeps compare values across the middle of the range and onto both endpoints, in both polarities. A design whose match at an endpoint were off by one would leave a one-tick spike in a waveform that should be flat. It writes a new compare value and a new ceiling in the middle of a period and checks that the current period still uses the old values. A design that loaded them at once would cut the period short or glitch the pulse. The bench also measures how long the count stays at zero under several prescaler divides, and it checks the TOP floor of 3. A wrong divide or a missing clamp would show up as the wrong dwell time or as a counter stuck at the bottom.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic {
        ST_RISE = 1'b0,
        ST_FALL = 1'b1
    } slope_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'b00,
        OM_RSV    = 2'b01,
        OM_NONINV = 2'b10,
        OM_INV    = 2'b11
    } omode_e;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_CMPA = 2'd1;
    localparam logic [1:0] ADR_CMPB = 2'd2;
    localparam logic [1:0] ADR_TOP  = 2'd3;

    localparam int MIN_TOP  = 3;
    localparam int CTRL_W   = 10;
    localparam int PRE_BITS = 10;

    // number of low prescaler bits that must all be one for a tick
    function automatic int div_shift(input logic [2:0] sel);
        case (sel)
            3'd2:    return 3;
            3'd3:    return 6;
            3'd4:    return 8;
            3'd5:    return 10;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
#(
    parameter int PRE_W = PRE_BITS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clk_sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    always_comb begin
        mask = PRE_W'((1 << div_shift(clk_sel)) - 1);
        unique case (clk_sel)
            3'd1, 3'd2, 3'd3, 3'd4, 3'd5: tick = ((pre_q & mask) == mask);
            default:                      tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          at_bottom,
    output logic [2:0]    clk_sel,
    output logic          top_from_a,
    output omode_e        mode_a,
    output omode_e        mode_b,
    output logic          en_a,
    output logic          en_b,
    output logic [CW-1:0] cmp_a_act,
    output logic [CW-1:0] cmp_b_act,
    output logic [CW-1:0] top_reg_act
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [CW-1:0]     cmp_a_buf, cmp_b_buf, top_buf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            cmp_a_buf <= '0;
            cmp_b_buf <= '0;
            top_buf   <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADR_CTRL: ctrl_q    <= wr_data[CTRL_W-1:0];
                ADR_CMPA: cmp_a_buf <= wr_data;
                ADR_CMPB: cmp_b_buf <= wr_data;
                ADR_TOP:  top_buf   <= wr_data;
            endcase
        end
    end

    // active copies follow the buffers only while the count rests at zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_a_act   <= '0;
            cmp_b_act   <= '0;
            top_reg_act <= '0;
        end else if (at_bottom) begin
            cmp_a_act   <= cmp_a_buf;
            cmp_b_act   <= cmp_b_buf;
            top_reg_act <= top_buf;
        end
    end

    assign clk_sel    = ctrl_q[2:0];
    assign top_from_a = ctrl_q[3];
    assign mode_a     = omode_e'(ctrl_q[5:4]);
    assign mode_b     = omode_e'(ctrl_q[7:6]);
    assign en_a       = ctrl_q[8];
    assign en_b       = ctrl_q[9];
endmodule

// File: rtl/pwm_slope_fsm.sv
module pwm_slope_fsm
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] top_lim,
    output logic [CW-1:0] cnt,
    output logic          falling
);
    slope_e        state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW:0]   inc;

    assign inc = {1'b0, cnt_q} + 1'b1;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (tick) begin
            unique case (state_q)
                ST_RISE: begin
                    if (inc >= {1'b0, top_lim}) begin   // RISE_TO_FALL
                        cnt_d   = top_lim;
                        state_d = ST_FALL;
                    end else begin                      // RISE_STEP
                        cnt_d   = inc[CW-1:0];
                    end
                end
                ST_FALL: begin
                    if (cnt_q <= CW'(1)) begin          // FALL_TO_RISE
                        cnt_d   = '0;
                        state_d = ST_RISE;
                    end else begin                      // FALL_STEP
                        cnt_d   = cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RISE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign cnt     = cnt_q;
    assign falling = (state_q == ST_FALL);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt,
    input  logic          falling,
    input  logic [CW-1:0] cmp,
    input  omode_e        mode,
    input  logic          en,
    output logic          pin
);
    logic level;

    always_comb begin
        level = falling ? (cnt <= cmp) : (cnt < cmp);
        unique case (mode)
            OM_NONINV:     pin = en & level;
            OM_INV:        pin = en & ~level;
            OM_OFF, OM_RSV: pin = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope
    import pwm_pkg::*;
#(
    parameter int CW    = 16,
    parameter int PRE_W = PRE_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic          pwm_a,
    output logic          pwm_b,
    output logic [CW-1:0] cnt_o,
    output logic          down_o
);
    localparam int NCH = 2;

    logic [2:0]    clk_sel;
    logic          top_from_a, en_a, en_b, tick, at_bottom;
    omode_e        mode_a, mode_b;
    logic [CW-1:0] cmp_a_act, cmp_b_act, top_reg_act, top_raw, top_lim;

    pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tick(tick)
    );

    pwm_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .at_bottom(at_bottom), .clk_sel(clk_sel),
        .top_from_a(top_from_a), .mode_a(mode_a), .mode_b(mode_b),
        .en_a(en_a), .en_b(en_b), .cmp_a_act(cmp_a_act),
        .cmp_b_act(cmp_b_act), .top_reg_act(top_reg_act)
    );

    assign top_raw = top_from_a ? cmp_a_act : top_reg_act;
    assign top_lim = (top_raw < CW'(MIN_TOP)) ? CW'(MIN_TOP) : top_raw;

    pwm_slope_fsm #(.CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .top_lim(top_lim),
        .cnt(cnt_o), .falling(down_o)
    );

    assign at_bottom = (cnt_o == '0);

    logic [CW-1:0] ch_cmp  [NCH];
    omode_e        ch_mode [NCH];
    logic          ch_en   [NCH];
    logic          ch_pin  [NCH];

    assign ch_cmp[0]  = cmp_a_act;
    assign ch_cmp[1]  = cmp_b_act;
    assign ch_mode[0] = mode_a;
    assign ch_mode[1] = mode_b;
    assign ch_en[0]   = en_a;
    assign ch_en[1]   = en_b;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_channel #(.CW(CW)) u_ch (
            .cnt(cnt_o), .falling(down_o), .cmp(ch_cmp[g]),
            .mode(ch_mode[g]), .en(ch_en[g]), .pin(ch_pin[g])
        );
    end

    assign pwm_a = ch_pin[0];
    assign pwm_b = ch_pin[1];
endmodule

// File: rtl/pwm_dual_slope_chk.sv
module pwm_dual_slope_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic [CW-1:0] cnt,
    input logic          down,
    input logic [CW-1:0] top_lim,
    input logic [CW-1:0] cmp_b_act,
    input logic [1:0]    mode_a,
    input logic [1:0]    mode_b,
    input logic          en_b,
    input logic          pwm_a,
    input logic          pwm_b
);
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1));

    a_r1_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= top_lim);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    a_r2_dir_top: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == top_lim) |-> down);

    a_r2_dir_bot: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !down);

    a_r10_hold_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> $stable(cmp_b_act));

    a_r11_gate_b: assert property (@(posedge clk) disable iff (!rst_n)
        !en_b |-> !pwm_b);

    a_r12_off_a: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a[1] == 1'b0) |-> !pwm_a);

    a_r5_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_b_act == '0 && mode_b == 2'b10) |-> !pwm_b);
endmodule

bind pwm_dual_slope pwm_dual_slope_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt_o), .down(down_o),
    .top_lim(top_lim), .cmp_b_act(cmp_b_act), .mode_a(mode_a),
    .mode_b(mode_b), .en_b(en_b), .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/sim_pwm_dual_slope.sv
`timescale 1ns/1ps
module sim_pwm_dual_slope;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_a, pwm_b, down_o;
    logic [15:0] cnt_o;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    pwm_dual_slope u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b),
        .cnt_o(cnt_o), .down_o(down_o)
    );

    // top, cmp_b, mode_b, expected high ticks of pwm_b in one period
    localparam int NV = 9;
    localparam int VEC [NV][4] = '{
        '{10,  3, 2,  6},   // R3
        '{10,  3, 3, 14},   // R4
        '{10,  0, 2,  0},   // R5
        '{10, 10, 2, 20},   // R5
        '{10, 15, 3,  0},   // R5
        '{ 8,  0, 3, 16},   // R5
        '{20,  7, 2, 14},   // R3
        '{ 6,  5, 0,  0},   // R12
        '{ 1,  2, 2,  4}    // R7: ceiling floor of 3
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int sel, input int topa, input int ma,
                                       input int mb, input int ea, input int eb);
        return 16'(sel | (topa << 3) | (ma << 4) | (mb << 6) | (ea << 8) | (eb << 9));
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic setup(input int top, input int ca, input int cb, input logic [15:0] ctl);
        do_reset();
        wr(2'd3, 16'(top));
        wr(2'd1, 16'(ca));
        wr(2'd2, 16'(cb));
        wr(2'd0, ctl);
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_at(input int v, input bit d, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            if (cnt_o == 16'(v) && down_o == d) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit ok;
        int hi, zeros, mx, t;

        // R13 reset state
        @(negedge clk);
        check(cnt_o == 0 && down_o == 0 && pwm_a == 0 && pwm_b == 0,
              "R13 reset state", int'(cnt_o), 0);

        // vector table: duty per period on channel B
        for (int v = 0; v < NV; v++) begin
            setup(VEC[v][0], 0, VEC[v][1], mk(1, 0, 0, VEC[v][2], 0, 1));
            t = (VEC[v][0] < 3) ? 3 : VEC[v][0];
            hi = 0;
            for (int i = 0; i < 2 * t; i++) begin
                hi += int'(pwm_b);
                @(negedge clk);
            end
            check(hi == VEC[v][3], $sformatf("R3/R4/R5 vector %0d high ticks", v), hi, VEC[v][3]);
        end

        // R1/R2 exact count sequence, TOP=5
        setup(5, 0, 0, mk(1, 0, 0, 0, 0, 0));
        wait_at(0, 1'b0, ok);
        for (int k = 1; k <= 11; k++) begin
            int e;
            bit ed;
            @(negedge clk);
            e  = (k <= 5) ? k : (k <= 10 ? 10 - k : k - 10);
            ed = (k >= 5 && k < 10);
            check(cnt_o == 16'(e), "R1 count sequence", int'(cnt_o), e);
            check(down_o == ed, "R2 slope flag", int'(down_o), int'(ed));
        end

        // R6 TOP from compare A; R11 enabled channel A at cmp==TOP stays high
        setup(5, 12, 0, mk(1, 1, 2, 0, 1, 0));
        mx = 0; zeros = 0; hi = 0;
        for (int i = 0; i < 24; i++) begin
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
            zeros += (cnt_o == 0) ? 1 : 0;
            hi += int'(pwm_a);
            @(negedge clk);
        end
        check(mx == 12, "R6 peak uses compare A", mx, 12);
        check(zeros == 1, "R6 one bottom per period", zeros, 1);
        check(hi == 24, "R5 channel A full high", hi, 24);

        // R11 enable gate off
        setup(10, 0, 10, mk(1, 0, 0, 2, 0, 0));
        hi = 0;
        for (int i = 0; i < 20; i++) begin hi += int'(pwm_b); @(negedge clk); end
        check(hi == 0, "R11 disabled pin low", hi, 0);

        // R12 reserved mode 01 on channel A
        setup(10, 10, 0, mk(1, 0, 1, 0, 1, 0));
        hi = 0;
        for (int i = 0; i < 20; i++) begin hi += int'(pwm_a); @(negedge clk); end
        check(hi == 0, "R12 mode 01 pin low", hi, 0);

        // R8 prescaler dwell at bottom
        setup(4, 0, 0, mk(2, 0, 0, 0, 0, 0));
        zeros = 0;
        for (int i = 0; i < 64; i++) begin zeros += (cnt_o == 0) ? 1 : 0; @(negedge clk); end
        check(zeros == 8, "R8 div8 bottom dwell", zeros, 8);

        setup(3, 0, 0, mk(3, 0, 0, 0, 0, 0));
        zeros = 0;
        for (int i = 0; i < 384; i++) begin zeros += (cnt_o == 0) ? 1 : 0; @(negedge clk); end
        check(zeros == 64, "R8 div64 bottom dwell", zeros, 64);

        setup(3, 0, 0, mk(5, 0, 0, 0, 0, 0));
        zeros = 0;
        for (int i = 0; i < 6144; i++) begin zeros += (cnt_o == 0) ? 1 : 0; @(negedge clk); end
        check(zeros == 1024, "R8 div1024 bottom dwell", zeros, 1024);

        // R9 stopped selects
        setup(5, 0, 0, mk(0, 0, 0, 0, 0, 0));
        mx = 0;
        for (int i = 0; i < 100; i++) begin if (int'(cnt_o) > mx) mx = int'(cnt_o); @(negedge clk); end
        check(mx == 0, "R9 select 0 holds", mx, 0);

        setup(5, 0, 0, mk(1, 0, 0, 0, 0, 0));
        repeat (3) @(negedge clk);
        t = int'(cnt_o);
        wr(2'd0, mk(7, 0, 0, 0, 0, 0));
        t = int'(cnt_o);
        mx = 0;
        for (int i = 0; i < 50; i++) begin if (int'(cnt_o) != t) mx++; @(negedge clk); end
        check(mx == 0, "R9 select 7 holds", mx, 0);

        // R10 compare write mid-period
        setup(10, 0, 3, mk(1, 0, 0, 2, 0, 1));
        wait_at(2, 1'b0, ok);
        wr(2'd2, 16'd8);
        wait_at(7, 1'b1, ok);
        check(ok && pwm_b == 1'b0, "R10 old compare kept", int'(pwm_b), 0);
        wait_at(0, 1'b0, ok);
        wait_at(7, 1'b1, ok);
        check(ok && pwm_b == 1'b1, "R10 new compare after bottom", int'(pwm_b), 1);

        // R10 ceiling write mid-period
        setup(10, 0, 0, mk(1, 0, 0, 0, 0, 0));
        wait_at(2, 1'b0, ok);
        wr(2'd3, 16'd14);
        mx = 0;
        for (int i = 0; i < 100 && cnt_o != 0; i++) begin
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
            @(negedge clk);
        end
        check(mx == 10, "R10 current period keeps ceiling", mx, 10);
        @(negedge clk);
        mx = 0;
        for (int i = 0; i < 100 && cnt_o != 0; i++) begin
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
            @(negedge clk);
        end
        check(mx == 14, "R10 next period new ceiling", mx, 14);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule